// File: doc/BRIEF.md
# Carry-Rotating Signature Accumulator

This block folds a stream of multiplier products into one signature while a self-test session runs. It keeps a running sum that is NX+NY bits wide, which is the width of the product. On each cycle that a product is marked valid, the block adds that product to the sum.

In self-test mode the carry out of the top bit is kept in one extra flip-flop. That bit is added back as the carry into the next addition, so no carry is lost over a long sequence. Outside self-test the carry into the adder is held at zero and the block behaves as an ordinary wrapping accumulator. This is the case when the same adder serves the normal datapath.

A session works as follows:
1. A clear pulse starts the session.
2. One valid product arrives per applied vector: 256 vectors from a binary counter, or 255 from a maximal-length shift register.
3. An end-of-test pulse compares the carry bit and the sum against an expected signature.
4. The verdict, pass or fail, is held together with the frozen signature until the next clear.

Top module: `sigacc_top`

## Requirements
- R1: When `productValid` is high, and no clear, end-of-test or held verdict applies, the sum `accumOut[W-1:0]` becomes (sum + product + carry-in) mod 2^W in the next cycle, with W = NX+NY.
- R2: In self-test mode (`bistMode` = 1), an accumulation stores the adder's carry out in the carry flip-flop, seen as `accumOut[W]`. That bit is the carry-in of the following accumulation.
- R3: In normal mode (`bistMode` = 0), an accumulation uses a carry-in of 0 and loads 0 into the carry flip-flop.
- R4: A cycle with `productValid` low leaves `accumOut` unchanged.
- R5: `clear` zeroes the sum, the carry bit, `testPass` and `testFail` in the next cycle. It takes priority over `productValid` and `endTest` in the same cycle.
- R6: `endTest` with no verdict held and no clear sets one of the two verdict outputs in the next cycle. `testPass` goes high if `{carry, sum}` equals `expectSig` in all W+1 bits, with bit W compared against the carry. Otherwise `testFail` goes high.
- R7: Once a verdict is held, `accumOut`, `testPass` and `testFail` stay unchanged until a clear, whatever `productValid` and `endTest` do. A product offered in the same cycle as `endTest` is not added.
- R8: After reset, `accumOut` is 0 and both verdict outputs are low.
- R9: `testPass` and `testFail` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| product | input | NX+NY | Product to accumulate |
| productValid | input | 1 | Product is valid this cycle |
| bistMode | input | 1 | 1 = rotate the carry, 0 = carry-in forced to 0 |
| clear | input | 1 | Start a session: zero the state and the verdict |
| endTest | input | 1 | End of sequence: compare and latch the verdict |
| expectSig | input | NX+NY+1 | Expected {carry, sum} signature |
| accumOut | output | NX+NY+1 | {carry bit, sum} |
| testPass | output | 1 | Signature matched |
| testFail | output | 1 | Signature mismatched |

## Verification
The bench builds the block with NX = NY = 4, giving an 8-bit sum plus the carry bit. At this size a full 256-vector counter session and a 255-vector shift-register session of 4x4 products run in full. The sum also overflows often, so carry rotation and carry dropping are both exercised many times. Seeded random cycles then mix the two modes, clears, early end-of-test pulses and wrong signatures against a cycle model.

// File: rtl/sigacc_pkg.sv
package sigacc_pkg;
  typedef struct packed {
    logic clrAll;   // zero sum, carry and verdict
    logic accEn;    // add product this cycle
    logic carryEn;  // rotate carry (self-test mode)
    logic judge;    // compare and latch verdict
  } sigStrobes_t;
endpackage

// File: rtl/sigacc_adder.sv
module sigacc_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] chain;
  assign chain[0] = cin;

  for (genvar gi = 0; gi < W; gi++) begin : gBit
    assign sum[gi]       = opA[gi] ^ opB[gi] ^ chain[gi];
    assign chain[gi + 1] = (opA[gi] & opB[gi]) | (chain[gi] & (opA[gi] ^ opB[gi]));
  end

  assign cout = chain[W];
endmodule

// File: rtl/sigacc_ctrl.sv
module sigacc_ctrl
  import sigacc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        productValid,
  input  logic        bistMode,
  input  logic        endTest,
  output sigStrobes_t stb,
  output logic        verdictHeld
);
  logic doneQ;

  always_comb begin
    stb.clrAll  = clear;
    stb.judge   = endTest & ~clear & ~doneQ;
    stb.accEn   = productValid & ~clear & ~doneQ & ~endTest;
    stb.carryEn = bistMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          doneQ <= 1'b0;
    else if (clear)     doneQ <= 1'b0;
    else if (stb.judge) doneQ <= 1'b1;
  end

  assign verdictHeld = doneQ;

  // R7: once a verdict has been taken, only a clear releases it
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !clear) |=> doneQ);

  // R5: clear always releases the held verdict
  a_r5_clear_release: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> !doneQ);
endmodule

// File: rtl/sigacc_dp.sv
module sigacc_dp
  import sigacc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  sigStrobes_t  stb,
  input  logic [W-1:0] product,
  input  logic [W:0]   expectSig,
  output logic [W-1:0] accQ,
  output logic         carryQ,
  output logic         passQ,
  output logic         failQ
);
  localparam int WIDE = W + 1;

  logic [W-1:0] sumNext;
  logic         coutNext;
  logic         cinEff;
  logic         match;

  assign cinEff = stb.carryEn & carryQ;

  sigacc_adder #(.W(W)) uAdder (
    .opA (accQ),
    .opB (product),
    .cin (cinEff),
    .sum (sumNext),
    .cout(coutNext)
  );

  assign match = ({carryQ, accQ} == expectSig);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ   <= '0;
      carryQ <= 1'b0;
      passQ  <= 1'b0;
      failQ  <= 1'b0;
    end else if (stb.clrAll) begin
      accQ   <= '0;
      carryQ <= 1'b0;
      passQ  <= 1'b0;
      failQ  <= 1'b0;
    end else begin
      if (stb.accEn) begin
        accQ   <= sumNext;
        carryQ <= stb.carryEn ? coutNext : 1'b0;
      end
      if (stb.judge) begin
        passQ <= match;
        failQ <= ~match;
      end
    end
  end

  // R2: in self-test mode {carry,sum} equals old sum + product + old carry
  a_r2_carry_rotate: assert property (@(posedge clk) disable iff (!rstN)
    (stb.accEn && stb.carryEn) |=>
      ({carryQ, accQ} == ({1'b0, $past(accQ)} + {1'b0, $past(product)} + WIDE'($past(carryQ)))));

  // R3: in normal mode carry-in is zero and the carry bit is left at zero
  a_r3_carry_zero: assert property (@(posedge clk) disable iff (!rstN)
    (stb.accEn && !stb.carryEn) |=>
      (!carryQ && (accQ == W'($past(accQ) + $past(product)))));

  // R9: verdict outputs are mutually exclusive
  a_r9_verdict_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(passQ && failQ));
endmodule

// File: rtl/sigacc_top.sv
module sigacc_top
  import sigacc_pkg::*;
#(
  parameter int NX = 8,
  parameter int NY = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NX+NY-1:0] product,
  input  logic             productValid,
  input  logic             bistMode,
  input  logic             clear,
  input  logic             endTest,
  input  logic [NX+NY:0]   expectSig,
  output logic [NX+NY:0]   accumOut,
  output logic             testPass,
  output logic             testFail
);
  localparam int W = NX + NY;

  sigStrobes_t  stb;
  logic         verdictHeld;
  logic [W-1:0] accQ;
  logic         carryQ;

  sigacc_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .clear       (clear),
    .productValid(productValid),
    .bistMode    (bistMode),
    .endTest     (endTest),
    .stb         (stb),
    .verdictHeld (verdictHeld)
  );

  sigacc_dp #(.W(W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .product  (product),
    .expectSig(expectSig),
    .accQ     (accQ),
    .carryQ   (carryQ),
    .passQ    (testPass),
    .failQ    (testFail)
  );

  assign accumOut = {carryQ, accQ};

  // R5: clear zeroes state and verdict
  a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (accumOut == '0 && !testPass && !testFail));

  // R4: no valid product, no clear -> accumulator holds
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!productValid && !clear) |=> $stable(accumOut));

  // R7: held verdict freezes signature and outcome
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (verdictHeld && !clear) |=> ($stable(accumOut) && $stable(testPass) && $stable(testFail)));

  // R6: end-of-test with nothing held yields exactly one verdict
  a_r6_verdict_given: assert property (@(posedge clk) disable iff (!rstN)
    (endTest && !clear && !verdictHeld) |=> (testPass != testFail));
endmodule

// File: tb/sigacc_top_test.sv
`timescale 1ns/1ps
module sigacc_top_test;
  localparam int NX = 4;
  localparam int NY = 4;
  localparam int W  = NX + NY;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] product = '0;
  logic         productValid = 1'b0;
  logic         bistMode = 1'b0;
  logic         clear = 1'b0;
  logic         endTest = 1'b0;
  logic [W:0]   expectSig = '0;
  logic [W:0]   accumOut;
  logic         testPass;
  logic         testFail;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [W-1:0] mAcc;
  logic         mCarry;
  logic         mDone;
  logic         mPass;
  logic         mFail;

  always #2.5 clk = ~clk;

  sigacc_top #(.NX(NX), .NY(NY)) uut (
    .clk(clk), .rstN(rstN), .product(product), .productValid(productValid),
    .bistMode(bistMode), .clear(clear), .endTest(endTest), .expectSig(expectSig),
    .accumOut(accumOut), .testPass(testPass), .testFail(testFail)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W:0] addStep(input logic [W:0] st, input logic [W-1:0] p, input logic mode);
    logic [W:0] s;
    s = {1'b0, st[W-1:0]} + {1'b0, p} + {{W{1'b0}}, (mode & st[W])};
    if (!mode) s[W] = 1'b0;
    return s;
  endfunction

  function automatic logic [W-1:0] vecProduct(input logic [7:0] v);
    logic [7:0] pr;
    pr = {4'd0, v[3:0]} * {4'd0, v[7:4]};
    return W'(pr);
  endfunction

  function automatic logic [W:0] sessionSig(input bit useLfsr);
    logic [W:0] st;
    logic [7:0] g;
    st = '0;
    g = useLfsr ? 8'd1 : 8'd0;
    for (int k = 0; k < (useLfsr ? 255 : 256); k++) begin
      st = addStep(st, vecProduct(g), 1'b1);
      if (useLfsr) g = {g[6:0], g[7] ^ g[5] ^ g[4] ^ g[3]};
      else         g = g + 8'd1;
    end
    return st;
  endfunction

  task automatic step(input logic v, input logic [W-1:0] p, input logic m,
                      input logic c, input logic e, input logic [W:0] x);
    logic [W:0] ns;
    productValid = v; product = p; bistMode = m; clear = c; endTest = e; expectSig = x;
    @(posedge clk);
    if (c) begin
      mAcc = '0; mCarry = 1'b0; mDone = 1'b0; mPass = 1'b0; mFail = 1'b0;
    end else if (!mDone) begin
      if (e) begin
        mDone = 1'b1;
        mPass = ({mCarry, mAcc} == x);
        mFail = !mPass;
      end else if (v) begin
        ns = addStep({mCarry, mAcc}, p, m);
        mAcc = ns[W-1:0]; mCarry = ns[W];
      end
    end
    @(negedge clk);
    chk(accumOut === {mCarry, mAcc}, "R1 accum", 32'(accumOut), 32'({mCarry, mAcc}));
    chk(testPass === mPass && testFail === mFail, "R6 verdict",
        {30'd0, testPass, testFail}, {30'd0, mPass, mFail});
    chk(!(testPass && testFail), "R9 exclusive", {31'd0, testPass}, 32'd0);
  endtask

  task automatic runSession(input bit useLfsr, input bit goodSig);
    logic [7:0] g;
    logic [W:0] sig;
    sig = sessionSig(useLfsr);
    if (!goodSig) sig[0] = ~sig[0];
    step(0, '0, 1, 1, 0, '0);
    g = useLfsr ? 8'd1 : 8'd0;
    for (int k = 0; k < (useLfsr ? 255 : 256); k++) begin
      step(1, vecProduct(g), 1, 0, 0, '0);
      if (useLfsr) g = {g[6:0], g[7] ^ g[5] ^ g[4] ^ g[3]};
      else         g = g + 8'd1;
    end
    step(0, '0, 1, 0, 1, sig);
    chk(testPass === goodSig && testFail === !goodSig, "R6 session",
        {30'd0, testPass, testFail}, {30'd0, goodSig, !goodSig});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    mAcc = '0; mCarry = 1'b0; mDone = 1'b0; mPass = 1'b0; mFail = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(accumOut === '0 && !testPass && !testFail, "R8 reset", 32'(accumOut), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: 200 + 100 = 300 -> sum 44, carry 1; adding 0 then gives 45, carry 0
    step(0, '0, 1, 1, 0, '0);
    step(1, W'(200), 1, 0, 0, '0);
    step(1, W'(100), 1, 0, 0, '0);
    chk(accumOut === 9'h12C, "R2 carry kept", 32'(accumOut), 32'h12C);
    step(1, W'(0), 1, 0, 0, '0);
    chk(accumOut === 9'd45, "R2 carry rotated", 32'(accumOut), 32'd45);

    // R3: the same sums in normal mode drop the carry
    step(0, '0, 0, 1, 0, '0);
    step(1, W'(200), 0, 0, 0, '0);
    step(1, W'(100), 0, 0, 0, '0);
    chk(accumOut === 9'd44, "R3 carry dropped", 32'(accumOut), 32'd44);
    step(1, W'(0), 0, 0, 0, '0);
    chk(accumOut === 9'd44, "R3 no carry-in", 32'(accumOut), 32'd44);

    // R4: valid low leaves the state unchanged
    step(0, W'(77), 1, 0, 0, '0);
    chk(accumOut === 9'd44, "R4 idle hold", 32'(accumOut), 32'd44);

    // R5: clear wins over valid and end-of-test
    step(1, W'(9), 1, 1, 1, '0);
    chk(accumOut === '0 && !testPass && !testFail, "R5 clear priority", 32'(accumOut), 32'd0);

    // R7: product in the end-of-test cycle is not added; afterwards everything is frozen
    step(1, W'(5), 1, 0, 0, '0);
    step(1, W'(7), 1, 0, 1, 9'd5);
    chk(accumOut === 9'd5 && testPass, "R7 eot product ignored", 32'(accumOut), 32'd5);
    step(1, W'(33), 1, 0, 0, '0);
    step(0, '0, 1, 0, 1, 9'd99);
    chk(accumOut === 9'd5 && testPass && !testFail, "R7 frozen verdict",
        {23'd0, accumOut}, 32'd5);

    runSession(1'b0, 1'b1);
    runSession(1'b0, 1'b0);
    runSession(1'b1, 1'b1);
    runSession(1'b1, 1'b0);

    // R1/R6: seeded random mix against the cycle model
    for (int n = 0; n < 3000; n++) begin
      logic v, m, c, e;
      logic [W:0] x;
      v = ($urandom % 10) < 7;
      m = $urandom % 2;
      c = ($urandom % 50) == 0;
      e = ($urandom % 40) == 0;
      x = ($urandom % 2) ? {mCarry, mAcc} : (W+1)'($urandom);
      step(v, W'($urandom), m, c, e, x);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule